// File: doc/BRIEF.md
# Power Controller Request Sequencer

This block is the register-facing side of a power controller that serves two processor clusters. A host on a simple memory-mapped bus programs it. Three kinds of request can be started from the bus: a performance-level change for cluster A, one for cluster B, and a system-configuration read. Only one request is in flight at a time. A behavioural backend finishes each request after a fixed latency in clock cycles. It then reports success, or failure when the error-injection input is high at that moment.

The outcome of every request goes into a status word that holds a complete flag and an error flag for each request type. The level-sensitive interrupt stays high while any of those flags is set. Reading the status word returns the flags and clears them.

The block also holds a wake-up mask, a power-down enable per cluster and one resume-address mailbox word per CPU. Cluster A has two CPUs and cluster B has three. These are plain storage; the block does not act on them. An asynchronous active-low reset is released through a two-stage synchronizer, so the block responds two cycles after reset goes high.

Top module: `pcr_sequencer`

## Requirements
- R1: After reset, both level registers read 0, the status word (0x18) reads 0, the wake mask, both power-down enables and all mailboxes read 0, and `irq` is low.
- R2: Writing an index below 8 to the cluster A level register (0x00, type 0) or to the cluster B level register (0x08, type 1) while idle starts a change. Exactly LATENCY clock edges after the accepting edge, the register reads the new index and status bit 4*t (t = type) is set. Before that edge `irq` stays low and the level is unchanged.
- R3: A level write with an index of 8 or more sets status bit 4*t+1 at the accepting edge. No backend run follows, and the level is unchanged.
- R4: A start of any type while a request is in flight sets that type's error bit 4*t+1 at once. The running request still completes normally.
- R5: Writing the command register (0x10) with bit 31 set starts a type 2 request. The function code is in bits 23:20 and the word offset in bits 11:0. On success, 0x74 reads {8'h5A, function, 8'h00, offset} and status bit 8 is set. With bit 31 clear, nothing starts.
- R6: If `inj_err` is high at the completion edge, status bit 4*t+1 is set instead of bit 4*t. The level register or configuration result keeps its old value.
- R7: `irq` is high exactly while any status bit is set, and it stays high until the status word is read. That read returns the bits and clears them.
- R8: The wake mask (0x24, bits 11:0) and the power-down enables (0x30 for A, 0x34 for B, bit 0) read back what was written. So do the mailboxes at 0x68+4i (A, i<2) and 0x78+4i (B, i<3), which keep all 32 bits.
- R9: A read of an unmapped offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| inj_err | input | 1 | Backend failure request, sampled at completion |
| irq | output | 1 | Level-high request-outcome interrupt |

## Verification
A stuck busy flag or a lost latency count shows up on the first request that follows: `irq` either never rises or rises on an edge other than the LATENCY-th one. A bench that samples the cycle before and the cycle after that edge catches this within one request. A wrong type latch sets the flag in the wrong status group, or moves the other cluster's level. A bad reject path shows its error bit, or leaves it out, on the very next status read. Clear-on-read faults leave `irq` high after a read.

// File: rtl/pcr_pkg.sv
package pcr_pkg;
  typedef enum logic [1:0] {
    REQ_PERF_A = 2'd0,
    REQ_PERF_B = 2'd1,
    REQ_CFG    = 2'd2
  } req_t;

  localparam int NTYPES = 3;

  localparam logic [7:0] OFS_LVL_A  = 8'h00;
  localparam logic [7:0] OFS_LVL_B  = 8'h08;
  localparam logic [7:0] OFS_CMD    = 8'h10;
  localparam logic [7:0] OFS_STAT   = 8'h18;
  localparam logic [7:0] OFS_WMASK  = 8'h24;
  localparam logic [7:0] OFS_PDN_A  = 8'h30;
  localparam logic [7:0] OFS_PDN_B  = 8'h34;
  localparam logic [7:0] OFS_MBX_A  = 8'h68;
  localparam logic [7:0] OFS_CFG_RD = 8'h74;
  localparam logic [7:0] OFS_MBX_B  = 8'h78;

  localparam int CMD_GO_BIT = 31;

  // behavioural configuration-space answer
  function automatic logic [31:0] cfg_result(logic [3:0] func, logic [11:0] woff);
    return {8'h5A, func, 8'h00, woff};
  endfunction
endpackage

// File: rtl/pcr_backend.sv
module pcr_backend import pcr_pkg::*; #(
  parameter int LATENCY = 32,
  localparam int CW = $clog2(LATENCY + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  req_t type_i,
  input  logic inj_err_i,
  output logic busy_o,
  output logic done_o,
  output logic fail_o,
  output req_t type_o
);
  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;
  req_t          type_q, type_d;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    type_d = type_q;
    done_o = busy_q && (cnt_q == '0);
    if (done_o)      busy_d = 1'b0;
    else if (busy_q) cnt_d  = cnt_q - 1'b1;
    if (start_i && !busy_q) begin
      busy_d = 1'b1;
      cnt_d  = CW'(LATENCY - 1);
      type_d = type_i;
    end
  end

  assign fail_o = done_o && inj_err_i;
  assign busy_o = busy_q;
  assign type_o = type_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      type_q <= REQ_PERF_A;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      type_q <= type_d;
    end
  end
endmodule

// File: rtl/pcr_status.sv
module pcr_status import pcr_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NTYPES-1:0] set_ok_i,
  input  logic [NTYPES-1:0] set_err_i,
  input  logic              clr_i,
  output logic [4*NTYPES-1:0] status_o,
  output logic              irq_o
);
  logic [4*NTYPES-1:0] st_q, st_d;

  always_comb begin
    st_d = clr_i ? '0 : st_q;
    for (int t = 0; t < NTYPES; t++) begin
      if (set_ok_i[t])  st_d[4*t]     = 1'b1;
      if (set_err_i[t]) st_d[4*t + 1] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign status_o = st_q;
  assign irq_o    = |st_q;
endmodule

// File: rtl/pcr_sequencer.sv
module pcr_sequencer import pcr_pkg::*; #(
  parameter int LEVELS  = 8,
  parameter int LATENCY = 32,
  parameter int CPUS_A  = 2,
  parameter int CPUS_B  = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        inj_err,
  output logic        irq
);
  localparam int LVW  = $clog2(LEVELS);
  localparam int NMBX = CPUS_A + CPUS_B;

  // reset: asynchronous assert, synchronous release
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic wr_en, stat_rd;
  assign wr_en   = bus_sel && bus_wr;
  assign stat_rd = bus_sel && !bus_wr && (bus_addr == OFS_STAT);

  logic eng_busy, eng_done, eng_fail, go;
  req_t eng_type, go_type;
  logic req_a, req_b, req_c;
  logic [NTYPES-1:0] rej, set_ok, set_err;
  logic [4*NTYPES-1:0] status;

  assign req_a = wr_en && (bus_addr == OFS_LVL_A);
  assign req_b = wr_en && (bus_addr == OFS_LVL_B);
  assign req_c = wr_en && (bus_addr == OFS_CMD) && bus_wdata[CMD_GO_BIT];

  always_comb begin
    rej[0]  = req_a && (eng_busy || (bus_wdata >= 32'(LEVELS)));
    rej[1]  = req_b && (eng_busy || (bus_wdata >= 32'(LEVELS)));
    rej[2]  = req_c && eng_busy;
    go      = (req_a && !rej[0]) || (req_b && !rej[1]) || (req_c && !rej[2]);
    go_type = req_c ? REQ_CFG : (req_b ? REQ_PERF_B : REQ_PERF_A);
    for (int t = 0; t < NTYPES; t++) begin
      set_ok[t]  = eng_done && !eng_fail && (eng_type == req_t'(t));
      set_err[t] = rej[t] || (eng_done && eng_fail && (eng_type == req_t'(t)));
    end
  end

  pcr_backend #(.LATENCY(LATENCY)) u_backend (
    .clk(clk), .rst_n(rst_sync_n), .start_i(go), .type_i(go_type),
    .inj_err_i(inj_err), .busy_o(eng_busy), .done_o(eng_done),
    .fail_o(eng_fail), .type_o(eng_type)
  );

  pcr_status u_status (
    .clk(clk), .rst_n(rst_sync_n), .set_ok_i(set_ok), .set_err_i(set_err),
    .clr_i(stat_rd), .status_o(status), .irq_o(irq)
  );

  // control and configuration state
  logic [LVW-1:0] lvl_a_q, lvl_a_d, lvl_b_q, lvl_b_d, tgt_q, tgt_d;
  logic [3:0]     fn_q, fn_d;
  logic [11:0]    off_q, off_d, mask_q, mask_d;
  logic [31:0]    cfg_q, cfg_d;
  logic           pdn_a_q, pdn_a_d, pdn_b_q, pdn_b_d;

  always_comb begin
    lvl_a_d = lvl_a_q;
    lvl_b_d = lvl_b_q;
    tgt_d   = tgt_q;
    fn_d    = fn_q;
    off_d   = off_q;
    cfg_d   = cfg_q;
    mask_d  = mask_q;
    pdn_a_d = pdn_a_q;
    pdn_b_d = pdn_b_q;
    if (go) begin
      tgt_d = bus_wdata[LVW-1:0];
      fn_d  = bus_wdata[23:20];
      off_d = bus_wdata[11:0];
    end
    if (eng_done && !eng_fail) begin
      case (eng_type)
        REQ_PERF_A: lvl_a_d = tgt_q;
        REQ_PERF_B: lvl_b_d = tgt_q;
        REQ_CFG:    cfg_d   = cfg_result(fn_q, off_q);
        default:    ;
      endcase
    end
    if (wr_en) begin
      case (bus_addr)
        OFS_WMASK: mask_d  = bus_wdata[11:0];
        OFS_PDN_A: pdn_a_d = bus_wdata[0];
        OFS_PDN_B: pdn_b_d = bus_wdata[0];
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      lvl_a_q <= '0;
      lvl_b_q <= '0;
      tgt_q   <= '0;
      fn_q    <= '0;
      off_q   <= '0;
      cfg_q   <= '0;
      mask_q  <= '0;
      pdn_a_q <= 1'b0;
      pdn_b_q <= 1'b0;
    end else begin
      lvl_a_q <= lvl_a_d;
      lvl_b_q <= lvl_b_d;
      tgt_q   <= tgt_d;
      fn_q    <= fn_d;
      off_q   <= off_d;
      cfg_q   <= cfg_d;
      mask_q  <= mask_d;
      pdn_a_q <= pdn_a_d;
      pdn_b_q <= pdn_b_d;
    end
  end

  // resume-address mailboxes, one word per CPU
  logic [31:0] mbx_q [NMBX];
  logic [7:0]  mbx_a [NMBX];

  for (genvar i = 0; i < NMBX; i++) begin : g_mbx
    localparam logic [7:0] MA = (i < CPUS_A) ? OFS_MBX_A + 8'(4 * i)
                                             : OFS_MBX_B + 8'(4 * (i - CPUS_A));
    logic [31:0] q, d;
    always_comb d = (wr_en && (bus_addr == MA)) ? bus_wdata : q;
    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n) q <= '0;
      else             q <= d;
    end
    assign mbx_q[i] = q;
    assign mbx_a[i] = MA;
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_LVL_A:  bus_rdata = 32'(lvl_a_q);
      OFS_LVL_B:  bus_rdata = 32'(lvl_b_q);
      OFS_STAT:   bus_rdata = 32'(status);
      OFS_WMASK:  bus_rdata = 32'(mask_q);
      OFS_PDN_A:  bus_rdata = 32'(pdn_a_q);
      OFS_PDN_B:  bus_rdata = 32'(pdn_b_q);
      OFS_CFG_RD: bus_rdata = cfg_q;
      default:    ;
    endcase
    for (int i = 0; i < NMBX; i++)
      if (bus_addr == mbx_a[i]) bus_rdata = mbx_q[i];
  end
endmodule

// File: rtl/pcr_sequencer_chk.sv
module pcr_sequencer_chk import pcr_pkg::*; #(
  parameter int LVW = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           irq,
  input logic           stat_rd,
  input logic           busy,
  input logic           done,
  input logic           fail,
  input req_t           cur_type,
  input logic [LVW-1:0] lvl_a,
  input logic           go,
  input logic           rej_any
);
  // R7
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !stat_rd |=> irq);

  // R7
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd && !done && !rej_any |=> !irq);

  // R2
  lvl_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lvl_a) |-> $past(done && !fail && cur_type == REQ_PERF_A));

  // R4
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(go));

  // R6
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> irq);
endmodule

bind pcr_sequencer pcr_sequencer_chk #(.LVW(LVW)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .irq(irq), .stat_rd(stat_rd),
  .busy(eng_busy), .done(eng_done), .fail(eng_fail), .cur_type(eng_type),
  .lvl_a(lvl_a_q), .go(go), .rej_any(|rej)
);

// File: tb/pcr_sequencer_tb_top.sv
module pcr_sequencer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 20;

  logic clk, rst_n, bus_sel, bus_wr, inj_err;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic irq;
  int nchk = 0, nerr = 0;

  pcr_sequencer #(.LATENCY(LAT)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .inj_err(inj_err), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [31:0] exp_cfg(logic [31:0] cmd);
    return {8'h5A, cmd[23:20], 8'h00, cmd[11:0]};
  endfunction
  function automatic logic [7:0] reg_addr(int k);
    if (k < 2) return 8'h68 + 8'(4 * k);
    if (k < 5) return 8'h78 + 8'(4 * (k - 2));
    if (k == 5) return 8'h24;
    if (k == 6) return 8'h30;
    return 8'h34;
  endfunction
  function automatic logic [31:0] reg_keep(int k, logic [31:0] d);
    if (k < 5) return d;
    if (k == 5) return d & 32'hFFF;
    return d & 32'h1;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask
  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask
  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask
  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    logic [31:0] v, cmd;
    logic [31:0] shadow [8];
    logic [2:0]  la, lb;
    void'($urandom(32'd4021));
    rst_n = 1'b0; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0; inj_err = 0;
    idle(3);
    rst_n = 1'b1;
    idle(3);

    // R1 reset state
    chk("R1 irq", 32'(irq), 0);
    rd(8'h18, v); chk("R1 status", v, 0);
    rd(8'h00, v); chk("R1 level A", v, 0);
    rd(8'h08, v); chk("R1 level B", v, 0);
    for (int k = 0; k < 8; k++) begin
      shadow[k] = 0;
      rd(reg_addr(k), v); chk("R1 storage", v, 0);
    end

    // R2 exact latency, cluster A
    wr(8'h00, 32'd5);
    idle(LAT - 1);
    chk("R2 irq before edge", 32'(irq), 0);
    idle(1);
    chk("R2 irq at edge", 32'(irq), 1);
    rd(8'h00, v); chk("R2 level A", v, 5);
    rd(8'h18, v); chk("R2 R7 status A ok", v, 32'h1);
    chk("R7 irq cleared", 32'(irq), 0);
    // R2 cluster B
    wr(8'h08, 32'd3);
    idle(LAT);
    rd(8'h18, v); chk("R2 status B ok", v, 32'h10);
    rd(8'h08, v); chk("R2 level B", v, 3);

    // R3 out-of-range index
    wr(8'h00, 32'd9);
    chk("R3 immediate irq", 32'(irq), 1);
    idle(LAT + 2);
    chk("R7 irq held", 32'(irq), 1);
    rd(8'h18, v); chk("R3 status A err", v, 32'h2);
    rd(8'h00, v); chk("R3 level A kept", v, 5);
    idle(LAT + 2);
    chk("R3 no backend run", 32'(irq), 0);

    // R4 start while busy
    wr(8'h08, 32'd6);
    wr(8'h00, 32'd1);
    chk("R4 reject irq", 32'(irq), 1);
    rd(8'h18, v); chk("R4 status A err", v, 32'h2);
    idle(LAT);
    rd(8'h18, v); chk("R4 running B ok", v, 32'h10);
    rd(8'h08, v); chk("R4 level B", v, 6);
    rd(8'h00, v); chk("R4 level A kept", v, 5);

    // R5 configuration read
    cmd = 32'h8060_0304;
    wr(8'h10, cmd);
    idle(LAT);
    rd(8'h18, v); chk("R5 status cfg ok", v, 32'h100);
    rd(8'h74, v); chk("R5 result", v, exp_cfg(cmd));
    wr(8'h10, 32'h0060_0111);
    idle(LAT + 2);
    chk("R5 no start without go", 32'(irq), 0);
    rd(8'h74, v); chk("R5 result kept", v, exp_cfg(cmd));

    // R6 injected failures
    inj_err = 1'b1;
    wr(8'h00, 32'd2);
    idle(LAT);
    rd(8'h18, v); chk("R6 status A err", v, 32'h2);
    rd(8'h00, v); chk("R6 level A kept", v, 5);
    wr(8'h10, 32'h80A0_0FFF);
    idle(LAT);
    rd(8'h18, v); chk("R6 status cfg err", v, 32'h200);
    rd(8'h74, v); chk("R6 result kept", v, exp_cfg(cmd));
    inj_err = 1'b0;

    // R8 random storage traffic
    for (int n = 0; n < 24; n++) begin
      int k;
      k = int'($urandom % 8);
      v = $urandom;
      wr(reg_addr(k), v);
      shadow[k] = reg_keep(k, v);
    end
    for (int k = 0; k < 8; k++) begin
      rd(reg_addr(k), v); chk("R8 readback", v, shadow[k]);
    end

    // R9 unmapped
    rd(8'h40, v); chk("R9 unmapped", v, 0);
    rd(8'hFC, v); chk("R9 unmapped high", v, 0);

    // R2 R3 random level requests
    la = 3'd5; lb = 3'd6;
    for (int n = 0; n < 12; n++) begin
      int cl, lv;
      cl = int'($urandom % 2);
      lv = int'($urandom % 12);
      wr(cl ? 8'h08 : 8'h00, 32'(lv));
      idle(LAT + 1);
      rd(8'h18, v);
      chk("R2 R3 random status", v, (lv < 8) ? (32'h1 << (4 * cl)) : (32'h2 << (4 * cl)));
      if (lv < 8) begin
        if (cl == 0) la = 3'(lv); else lb = 3'(lv);
      end
      rd(8'h00, v); chk("R2 random level A", v, 32'(la));
      rd(8'h08, v); chk("R2 random level B", v, 32'(lb));
    end

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule